// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration front end of a legacy I/O controller. A host reaches it through two byte-wide locations: offset 0 takes a register number (or a lock command), and offset 1 carries the data for whichever register that number selects. A fixed unlock key written to offset 0 opens configuration mode, and a second key closes it. While the block is locked, the configuration space cannot be read or changed.

Global registers hold a fixed identity byte, a revision byte, three power and clock control bytes, and the number of the logical device being configured. That device number switches the upper register window between separate storage banks. There is one bank for each supported device, and each bank holds an enable bit, a 16-bit base address, two interrupt selects and a mode byte. The block drives each device's enable, base address and interrupt selects straight from its bank, so the peripherals attached to it pick up new settings one clock after the host writes them.

Top module: `cfg_index_port`

## Requirements
- R1: Offset 0 (`bus_addr`=0) is the index/command port and offset 1 is the data port. A read loads `bus_rdata` on the clock edge at which `bus_rd` is sampled high, and `bus_rdata` holds that value until the next read.
- R2: After reset the block is locked. Writing 0x55 to offset 0 while locked unlocks it. Writing 0xAA to offset 0 while unlocked locks it again and leaves the stored index unchanged. Any other offset-0 write while unlocked stores that byte as the index.
- R3: While locked, reads of either offset return 0xFF, data writes are ignored, and offset-0 writes other than 0x55 leave the stored index unchanged.
- R4: Register 0x20 reads the identity 0x4D, and register 0x21 reads the revision byte (0x01 by default). Writes to these two registers have no effect.
- R5: Register 0x07 is a read/write byte that holds the current logical-device number.
- R6: Registers 0x22, 0x23 and 0x24 are read/write bytes with a reset value of 0x00.
- R7: Each supported device number (0x00, 0x04, 0x05, 0x07) has its own bank. In that bank, 0x30 bit 0 is the enable bit (it reads back as 0x00 or 0x01), 0x60 and 0x61 are the high and low bytes of the base address, 0x70 and 0x72 are the two interrupt selects, and 0xF0 is the mode byte.
- R8: A data write reaches only the bank selected by register 0x07. Changing 0x07 and then restoring it leaves the contents of every bank unchanged.
- R9: Reads of unimplemented register numbers, or of bank registers while 0x07 holds an unsupported number, return 0x00. Writes to them are discarded.
- R10: The device outputs are ordered by slot: slot 0 is device 0x00, slot 1 is 0x04, slot 2 is 0x05 and slot 3 is 0x07. For each slot, `dev_active` is the enable bit, `dev_base` is {0x60, 0x61}, and `dev_irq_a` and `dev_irq_b` are 0x70 and 0x72. Each output changes on the clock edge that samples the data write.
- R11: Reset clears every bank, every power register, register 0x07 and the index, and sets `bus_rdata` to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| dev_active | output | 4 | Enable bit per slot |
| dev_base | output | 64 | 16-bit base address per slot, slot s at bits [16s+15:16s] |
| dev_irq_a | output | 32 | First interrupt select per slot, slot s at bits [8s+7:8s] |
| dev_irq_b | output | 32 | Second interrupt select per slot, slot s at bits [8s+7:8s] |

## Verification
The bench goes after four corner cases:

- **Hijacked index while locked.** A stray index write made while locked must not survive into configuration mode. A design that took the write would let a later data access reach the wrong register.
- **Close key clobbering the index.** Index reads check that the 0xAA close key does not overwrite the stored index. A design that wrongly stored it would return 0xAA on the next index read.
- **Bank aliasing and restore.** Switching the device number away and back must leave every bank's stored bytes and outputs intact. Banks that were shared or aliased would show another device's base address or interrupt.
- **Unsupported device numbers.** A write made while 0x07 holds a number with no bank must change nothing. A design that mis-decoded the number would move some slot's outputs.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int NSLOT = 4;
  localparam int DW    = 8;

  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] RG_LDN   = 8'h07;
  localparam logic [7:0] RG_ID    = 8'h20;
  localparam logic [7:0] RG_REV   = 8'h21;
  localparam logic [7:0] RG_PWR   = 8'h22;
  localparam logic [7:0] RG_PMG   = 8'h23;
  localparam logic [7:0] RG_OSC   = 8'h24;
  localparam logic [7:0] RG_ACT   = 8'h30;
  localparam logic [7:0] RG_BASEH = 8'h60;
  localparam logic [7:0] RG_BASEL = 8'h61;
  localparam logic [7:0] RG_IRQA  = 8'h70;
  localparam logic [7:0] RG_IRQB  = 8'h72;
  localparam logic [7:0] RG_MODE  = 8'hF0;

  typedef enum logic {ST_LOCKED = 1'b0, ST_OPEN = 1'b1} lock_e;

  typedef enum logic [2:0] {
    F_ACT, F_BASEH, F_BASEL, F_IRQA, F_IRQB, F_MODE, F_NONE
  } field_e;

  function automatic logic [7:0] slot_ldn(input int s);
    case (s)
      0:       return 8'h00;
      1:       return 8'h04;
      2:       return 8'h05;
      default: return 8'h07;
    endcase
  endfunction

  function automatic field_e decode_field(input logic [7:0] idx);
    case (idx)
      RG_ACT:   return F_ACT;
      RG_BASEH: return F_BASEH;
      RG_BASEL: return F_BASEL;
      RG_IRQA:  return F_IRQA;
      RG_IRQB:  return F_IRQB;
      RG_MODE:  return F_MODE;
      default:  return F_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         idx_wr,
  input  logic [W-1:0] wdata,
  output logic         open_o,
  output logic [W-1:0] index_o
);
  lock_e        st_q;
  logic [W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_LOCKED;
      idx_q <= '0;
    end else if (idx_wr) begin
      if (st_q == ST_LOCKED) begin
        if (wdata == W'(KEY_OPEN)) st_q <= ST_OPEN;
      end else if (wdata == W'(KEY_CLOSE)) begin
        st_q <= ST_LOCKED;
      end else begin
        idx_q <= wdata;
      end
    end
  end

  assign open_o  = (st_q == ST_OPEN);
  assign index_o = idx_q;

  assert_unlock_R2: assert property (@(posedge clk) disable iff (rst)
    (!open_o && idx_wr && wdata == W'(KEY_OPEN)) |=> open_o);
  assert_relock_R2: assert property (@(posedge clk) disable iff (rst)
    (open_o && idx_wr && wdata == W'(KEY_CLOSE)) |=> (!open_o && $stable(index_o)));
  assert_locked_index_R3: assert property (@(posedge clk) disable iff (rst)
    (!open_o) |=> $stable(index_o));
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_pkg::*;
#(
  parameter logic [7:0] ID_VAL  = 8'h4D,
  parameter logic [7:0] REV_VAL = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  output logic [7:0] ldn_o,
  output logic       hit_o,
  output logic [7:0] rdata_o
);
  logic [7:0] ldn_q, pwr_q, pmg_q, osc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q <= '0;
      pwr_q <= '0;
      pmg_q <= '0;
      osc_q <= '0;
    end else if (wr_en) begin
      case (index)
        RG_LDN:  ldn_q <= wdata;
        RG_PWR:  pwr_q <= wdata;
        RG_PMG:  pmg_q <= wdata;
        RG_OSC:  osc_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '0;
    case (index)
      RG_LDN:  rdata_o = ldn_q;
      RG_ID:   rdata_o = ID_VAL;
      RG_REV:  rdata_o = REV_VAL;
      RG_PWR:  rdata_o = pwr_q;
      RG_PMG:  rdata_o = pmg_q;
      RG_OSC:  rdata_o = osc_q;
      default: hit_o = 1'b0;
    endcase
  end

  assign ldn_o = ldn_q;

  assert_ldn_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && index == RG_LDN) |=> $stable(ldn_o));
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sel,
  input  logic        wr_en,
  input  logic [7:0]  index,
  input  logic [7:0]  wdata,
  output logic        active_o,
  output logic [15:0] base_o,
  output logic [7:0]  irq_a_o,
  output logic [7:0]  irq_b_o,
  output logic [7:0]  rdata_o
);
  logic       act_q;
  logic [7:0] bh_q, bl_q, ia_q, ib_q, md_q;
  field_e     fld;

  assign fld = decode_field(index);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      bh_q  <= '0;
      bl_q  <= '0;
      ia_q  <= '0;
      ib_q  <= '0;
      md_q  <= '0;
    end else if (wr_en && sel) begin
      case (fld)
        F_ACT:   act_q <= wdata[0];
        F_BASEH: bh_q  <= wdata;
        F_BASEL: bl_q  <= wdata;
        F_IRQA:  ia_q  <= wdata;
        F_IRQB:  ib_q  <= wdata;
        F_MODE:  md_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel) begin
      case (fld)
        F_ACT:   rdata_o = {7'b0, act_q};
        F_BASEH: rdata_o = bh_q;
        F_BASEL: rdata_o = bl_q;
        F_IRQA:  rdata_o = ia_q;
        F_IRQB:  rdata_o = ib_q;
        F_MODE:  rdata_o = md_q;
        default: ;
      endcase
    end
  end

  assign active_o = act_q;
  assign base_o   = {bh_q, bl_q};
  assign irq_a_o  = ia_q;
  assign irq_b_o  = ib_q;

  assert_bank_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel) |=> ($stable(base_o) && $stable(active_o) &&
                         $stable(irq_a_o) && $stable(irq_b_o)));
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_pkg::*;
#(
  parameter logic [7:0] ID_VAL  = 8'h4D,
  parameter logic [7:0] REV_VAL = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic [NSLOT-1:0]     dev_active,
  output logic [NSLOT*16-1:0]  dev_base,
  output logic [NSLOT*8-1:0]   dev_irq_a,
  output logic [NSLOT*8-1:0]   dev_irq_b
);
  logic             open;
  logic [7:0]       index;
  logic [7:0]       ldn;
  logic             g_hit;
  logic [7:0]       g_rdata;
  logic             idx_wr, data_wr;
  logic [NSLOT-1:0] sel_vec;
  logic [7:0]       bank_rd [NSLOT];
  logic [7:0]       bank_or;
  logic [7:0]       cfg_val;
  logic [7:0]       rdata_q;

  assign idx_wr  = bus_wr && !bus_addr;
  assign data_wr = bus_wr && bus_addr && open;

  cfg_key_fsm u_key (
    .clk     (clk),
    .rst     (rst),
    .idx_wr  (idx_wr),
    .wdata   (bus_wdata),
    .open_o  (open),
    .index_o (index)
  );

  cfg_global_regs #(.ID_VAL(ID_VAL), .REV_VAL(REV_VAL)) u_glb (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (data_wr),
    .index   (index),
    .wdata   (bus_wdata),
    .ldn_o   (ldn),
    .hit_o   (g_hit),
    .rdata_o (g_rdata)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign sel_vec[s] = (ldn == slot_ldn(s));
    cfg_dev_bank u_bank (
      .clk      (clk),
      .rst      (rst),
      .sel      (sel_vec[s]),
      .wr_en    (data_wr),
      .index    (index),
      .wdata    (bus_wdata),
      .active_o (dev_active[s]),
      .base_o   (dev_base[s*16 +: 16]),
      .irq_a_o  (dev_irq_a[s*8 +: 8]),
      .irq_b_o  (dev_irq_b[s*8 +: 8]),
      .rdata_o  (bank_rd[s])
    );
  end

  always_comb begin
    bank_or = '0;
    for (int s = 0; s < NSLOT; s++) bank_or = bank_or | bank_rd[s];
    cfg_val = g_hit ? g_rdata : bank_or;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      if (!open)         rdata_q <= 8'hFF;
      else if (bus_addr) rdata_q <= cfg_val;
      else               rdata_q <= index;
    end
  end

  assign bus_rdata = rdata_q;

  assert_locked_read_R3: assert property (@(posedge clk) disable iff (rst)
    (!open && bus_rd) |=> (bus_rdata == 8'hFF));
  assert_id_read_R4: assert property (@(posedge clk) disable iff (rst)
    (open && bus_rd && bus_addr && index == RG_ID) |=> (bus_rdata == ID_VAL));
  assert_unsup_read_R9: assert property (@(posedge clk) disable iff (rst)
    (open && bus_rd && bus_addr && sel_vec == '0 && !g_hit) |=> (bus_rdata == 8'h00));
  assert_one_bank_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_vec));
  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/cfg_index_port_tb.sv
module cfg_index_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  dev_active;
  logic [63:0] dev_base;
  logic [31:0] dev_irq_a, dev_irq_b;

  int checks = 0, errors = 0;

  // 125 MHz clock
  always #4 clk = ~clk;

  cfg_index_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_active(dev_active),
    .dev_base(dev_base), .dev_irq_a(dev_irq_a), .dev_irq_b(dev_irq_b)
  );

  // reference model state
  bit         m_open;
  logic [7:0] m_idx, m_ldn, m_pwr, m_pmg, m_osc;
  logic       m_act [4];
  logic [7:0] m_bh [4], m_bl [4], m_ia [4], m_ib [4], m_md [4];

  function automatic int slot_of(input logic [7:0] n);
    case (n)
      8'h00: return 0;
      8'h04: return 1;
      8'h05: return 2;
      8'h07: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic void model_reset();
    m_open = 0; m_idx = 0; m_ldn = 0; m_pwr = 0; m_pmg = 0; m_osc = 0;
    for (int s = 0; s < 4; s++) begin
      m_act[s] = 0; m_bh[s] = 0; m_bl[s] = 0; m_ia[s] = 0; m_ib[s] = 0; m_md[s] = 0;
    end
  endfunction

  function automatic void model_write(input logic a, input logic [7:0] d);
    int s;
    if (!a) begin
      if (!m_open) begin
        if (d == 8'h55) m_open = 1;
      end else if (d == 8'hAA) m_open = 0;
      else m_idx = d;
    end else if (m_open) begin
      s = slot_of(m_ldn);
      case (m_idx)
        8'h07: m_ldn = d;
        8'h22: m_pwr = d;
        8'h23: m_pmg = d;
        8'h24: m_osc = d;
        default:
          if (s >= 0) begin
            case (m_idx)
              8'h30: m_act[s] = d[0];
              8'h60: m_bh[s] = d;
              8'h61: m_bl[s] = d;
              8'h70: m_ia[s] = d;
              8'h72: m_ib[s] = d;
              8'hF0: m_md[s] = d;
              default: ;
            endcase
          end
      endcase
    end
  endfunction

  function automatic logic [7:0] model_read(input logic a);
    int s;
    if (!m_open) return 8'hFF;
    if (!a) return m_idx;
    s = slot_of(m_ldn);
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h4D;
      8'h21: return 8'h01;
      8'h22: return m_pwr;
      8'h23: return m_pmg;
      8'h24: return m_osc;
      default: ;
    endcase
    if (s < 0) return 8'h00;
    case (m_idx)
      8'h30: return {7'b0, m_act[s]};
      8'h60: return m_bh[s];
      8'h61: return m_bl[s];
      8'h70: return m_ia[s];
      8'h72: return m_ib[s];
      8'hF0: return m_md[s];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read_chk(input logic a, input string req);
    logic [7:0] e;
    e = model_read(a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check(req, {56'b0, bus_rdata}, {56'b0, e});
  endtask

  task automatic check_outputs(input string req);
    logic [63:0] eb;
    logic [31:0] ea, ebb;
    logic [3:0]  ev;
    for (int s = 0; s < 4; s++) begin
      ev[s] = m_act[s];
      eb[s*16 +: 16] = {m_bh[s], m_bl[s]};
      ea[s*8 +: 8] = m_ia[s];
      ebb[s*8 +: 8] = m_ib[s];
    end
    check({req, " active"}, {60'b0, dev_active}, {60'b0, ev});
    check({req, " base"}, dev_base, eb);
    check({req, " irq"}, {dev_irq_a, dev_irq_b}, {ea, ebb});
  endtask

  function automatic logic [7:0] pick_index(input int unsigned r);
    case (r % 15)
      0: return 8'h07;  1: return 8'h20;  2: return 8'h21;  3: return 8'h22;
      4: return 8'h23;  5: return 8'h24;  6: return 8'h30;  7: return 8'h60;
      8: return 8'h61;  9: return 8'h70; 10: return 8'h72; 11: return 8'hF0;
      12: return 8'h31; 13: return 8'h05; default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] pick_ldn(input int unsigned r);
    case (r % 7)
      0: return 8'h00; 1: return 8'h04; 2: return 8'h05; 3: return 8'h07;
      4: return 8'h01; 5: return 8'h06; default: return 8'(r >> 4);
    endcase
  endfunction

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h0C0F_FEE5);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    check("R11 rdata", {56'b0, bus_rdata}, 64'h0);
    check_outputs("R11");
    // R3: locked read of data port
    bus_read_chk(1'b1, "R3 locked read");
    // R3: locked index write ignored, locked data write ignored
    bus_write(1'b0, 8'h20);
    bus_write(1'b1, 8'h99);
    bus_write(1'b0, 8'h55);             // R2 unlock
    bus_read_chk(1'b0, "R3 index kept 00");
    // R4: identity and revision, writes ignored
    bus_write(1'b0, 8'h20); bus_write(1'b1, 8'h12);
    bus_read_chk(1'b1, "R4 id");
    bus_write(1'b0, 8'h21); bus_write(1'b1, 8'h34);
    bus_read_chk(1'b1, "R4 rev");
    // R6: power registers
    bus_write(1'b0, 8'h23); bus_write(1'b1, 8'h5A);
    bus_read_chk(1'b1, "R6 pmgt");
    // R7/R10: slot1 base address
    bus_write(1'b0, 8'h07); bus_write(1'b1, 8'h04);
    bus_read_chk(1'b1, "R5 ldn");
    bus_write(1'b0, 8'h60); bus_write(1'b1, 8'h03);
    bus_write(1'b0, 8'h61); bus_write(1'b1, 8'hF8);
    bus_write(1'b0, 8'h30); bus_write(1'b1, 8'hFF);
    check_outputs("R10 slot1");
    bus_read_chk(1'b1, "R7 active readback");
    // R8: switch to slot2, write, restore
    bus_write(1'b0, 8'h07); bus_write(1'b1, 8'h05);
    bus_write(1'b0, 8'h60); bus_write(1'b1, 8'h02);
    bus_write(1'b0, 8'h07); bus_write(1'b1, 8'h04);
    bus_write(1'b0, 8'h60);
    bus_read_chk(1'b1, "R8 restore slot1");
    check_outputs("R8");
    // R9: unsupported device number
    bus_write(1'b0, 8'h07); bus_write(1'b1, 8'h02);
    bus_write(1'b0, 8'h60); bus_write(1'b1, 8'h77);
    bus_read_chk(1'b1, "R9 unsupported bank");
    check_outputs("R9");
    bus_write(1'b0, 8'h44);
    bus_read_chk(1'b1, "R9 unimplemented");
    // R2: close key keeps index, then locked
    bus_write(1'b0, 8'hAA);
    bus_read_chk(1'b0, "R2 locked index read");
    bus_write(1'b0, 8'h55);
    bus_read_chk(1'b0, "R2 index after close");
    // R1: rdata holds without read strobe
    repeat (3) @(negedge clk);
    check("R1 hold", {56'b0, bus_rdata}, 64'h44);

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      int unsigned r, k;
      r = $urandom;
      k = r % 12;
      if (k == 0)      bus_write(1'b0, (r[8]) ? 8'h55 : 8'hAA);
      else if (k < 4)  bus_write(1'b0, pick_index(r >> 8));
      else if (k < 7)  bus_write(1'b1, (m_idx == 8'h07) ? pick_ldn(r >> 8) : 8'(r >> 8));
      else if (k < 11) bus_read_chk(1'b1, "R7 R8 R9 random read");
      else             bus_read_chk(1'b0, "R1 random index read");
      if (k >= 4 && k < 7) check_outputs("R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule